// File: doc/BRIEF.md
# Gated Reference Clock Divider

This block produces a divided copy of the crystal reference clock on a clock output pin, for use as a clock by a companion controller. One control bit picks the ratio: divide by 4 or divide by 8. The result has a 50% duty cycle. A 13 MHz reference therefore gives 3.25 MHz or 1.625 MHz.

The output is held low while the chip is powered down, while the crystal-ready flag is low, and while the clock-enable bit is clear. The crystal-ready flag and the clock-enable bit pass through a resynchronizer. Their combined gate drives a three-state machine: `ST_IDLE` holds the output low with the phase counter at zero, `ST_HIGH` is the high half-period and `ST_LOW` is the low half-period. The transitions are:

- `ST_IDLE` to `ST_HIGH` when the gate opens.
- `ST_HIGH` to `ST_LOW` when the half ends with the gate open.
- `ST_HIGH` to `ST_IDLE` when the half ends with the gate closed.
- `ST_LOW` to `ST_HIGH` when the half ends.
- `ST_LOW` to `ST_IDLE` as soon as the gate closes.

Start-up always begins a fresh high half from a counter at zero, so no runt pulse ever appears. A high half that is in progress always runs to completion. A new ratio is taken only at a falling boundary of the output.

Top module: `refclk_divider`

## Requirements
- R1: With `div_fast` = 1 the output repeats every 4 reference cycles: high for 2, then low for 2.
- R2: With `div_fast` = 0 the output repeats every 8 reference cycles: high for 4, then low for 4.
- R3: While `clk_en` is 0 and the output is low, the output stays low.
- R4: While `pwrdn_n` is 0 the output is 0, and it goes to 0 at once when `pwrdn_n` falls, with no wait for a reference edge.
- R5: The output stays low until `xtal_ready` and `clk_en` are both 1. It then goes high on the third reference rising edge after both are seen high (two resynchronizer stages plus one output register).
- R6: Every high pulse of the output is a full half-period of 2 or 4 reference cycles, including the first one after enabling.
- R7: After the output is gated off and enabled again, the first period is complete: the counter restarts from zero, and the first high and low halves have the full length.
- R8: A change of `div_fast` does not shorten the high half in progress. The new ratio applies from the next falling output edge, so the low half that follows uses the new length.
- R9: When `clk_en` falls during a high half, that half still completes at full length, and the output then stays low.
- R10: With `clk_en` at 1 and `xtal_ready` at 0, the output stays low. Raising `xtal_ready` starts the output with the same latency as R5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | Crystal reference clock |
| pwrdn_n | input | 1 | Asynchronous power-down, active low |
| xtal_ready | input | 1 | Crystal amplitude ready flag |
| clk_en | input | 1 | Clock output enable bit |
| div_fast | input | 1 | Ratio select: 1 = divide by 4, 0 = divide by 8 |
| clk_out | output | 1 | Divided, gated clock output |

## Verification
The output edge after enabling is due on the third reference rising edge after the gate inputs are driven. The bench drives those inputs on a falling edge and counts falling-edge samples until the first high sample, expecting exactly three. After that, every half-period is measured as a run of falling-edge samples of one level, so each high and low width is compared with 2 or 4 and is unaffected by process ordering at the rising edge. A ratio change or enable drop is applied on the first sample of a high half. The bench expects the old width for that half and the effects listed in R8 and R9 from the next falling edge onward. Power-down is checked one time unit after `pwrdn_n` falls, because that response is asynchronous.

// File: rtl/refclk_div_pkg.sv
package refclk_div_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HIGH = 2'd1,
        ST_LOW  = 2'd2
    } div_state_e;

    // Length of one half-period in reference cycles for the selected ratio.
    function automatic int unsigned half_len(input logic fast,
                                             input int unsigned half_fast,
                                             input int unsigned half_slow);
        return fast ? half_fast : half_slow;
    endfunction

endpackage

// File: rtl/refclk_sync.sv
module refclk_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic ref_clk,
    input  logic pwrdn_n,
    input  logic d_in,
    output logic q_out
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge ref_clk or negedge pwrdn_n) begin
                    if (!pwrdn_n) chain_q[0] <= 1'b0;
                    else          chain_q[0] <= d_in;
                end
            end else begin : g_next
                always_ff @(posedge ref_clk or negedge pwrdn_n) begin
                    if (!pwrdn_n) chain_q[s] <= 1'b0;
                    else          chain_q[s] <= chain_q[s-1];
                end
            end
        end
    endgenerate

    assign q_out = chain_q[STAGES-1];
endmodule

// File: rtl/refclk_phase_cnt.sv
module refclk_phase_cnt #(
    parameter int unsigned CNT_W = 2
) (
    input  logic             ref_clk,
    input  logic             pwrdn_n,
    input  logic             clr,
    input  logic [CNT_W:0]   limit,
    output logic             phase_last
);
    logic [CNT_W:0] cnt_q;

    always_ff @(posedge ref_clk or negedge pwrdn_n) begin
        if (!pwrdn_n)  cnt_q <= '0;
        else if (clr)  cnt_q <= '0;
        else           cnt_q <= cnt_q + 1'b1;
    end

    assign phase_last = (cnt_q == (limit - 1'b1));
endmodule

// File: rtl/refclk_div_fsm.sv
module refclk_div_fsm
    import refclk_div_pkg::*;
#(
    parameter int unsigned HALF_FAST = 2,
    parameter int unsigned HALF_SLOW = 4,
    parameter int unsigned CNT_W     = 2
) (
    input  logic           ref_clk,
    input  logic           pwrdn_n,
    input  logic           gate_on,
    input  logic           div_fast,
    input  logic           phase_last,
    output logic           cnt_clr,
    output logic [CNT_W:0] half_limit,
    output logic           clk_out
);
    div_state_e state_q, state_d;
    logic       ratio_q;
    logic       ratio_load;
    logic       out_q;

    // State register and latched ratio.
    always_ff @(posedge ref_clk or negedge pwrdn_n) begin
        if (!pwrdn_n) begin
            state_q <= ST_IDLE;
            ratio_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (ratio_load) ratio_q <= div_fast;
        end
    end

    // Next-state logic.
    always_comb begin
        state_d    = state_q;
        cnt_clr    = 1'b0;
        ratio_load = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                cnt_clr = 1'b1;
                if (gate_on) begin
                    state_d    = ST_HIGH;
                    ratio_load = 1'b1;
                end
            end
            ST_HIGH: begin
                if (phase_last) begin
                    cnt_clr    = 1'b1;
                    ratio_load = 1'b1;
                    state_d    = gate_on ? ST_LOW : ST_IDLE;
                end
            end
            ST_LOW: begin
                if (!gate_on) begin
                    state_d = ST_IDLE;
                    cnt_clr = 1'b1;
                end else if (phase_last) begin
                    state_d = ST_HIGH;
                    cnt_clr = 1'b1;
                end
            end
            default: begin
                state_d = ST_IDLE;
                cnt_clr = 1'b1;
            end
        endcase
    end

    // Output register: a single flop so the pin never glitches.
    always_ff @(posedge ref_clk or negedge pwrdn_n) begin
        if (!pwrdn_n) out_q <= 1'b0;
        else          out_q <= (state_d == ST_HIGH);
    end

    assign half_limit = (CNT_W + 1)'(half_len(ratio_q, HALF_FAST, HALF_SLOW));
    assign clk_out    = out_q;
endmodule

// File: rtl/refclk_divider.sv
module refclk_divider #(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned HALF_FAST   = 2,
    parameter int unsigned HALF_SLOW   = 4
) (
    input  logic ref_clk,
    input  logic pwrdn_n,
    input  logic xtal_ready,
    input  logic clk_en,
    input  logic div_fast,
    output logic clk_out
);
    localparam int unsigned CNT_W = $clog2(HALF_SLOW);

    logic           xtal_s;
    logic           en_s;
    logic           gate_on;
    logic           cnt_clr;
    logic           phase_last;
    logic [CNT_W:0] half_limit;

    refclk_sync #(.STAGES(SYNC_STAGES)) u_sync_xtal (
        .ref_clk (ref_clk),
        .pwrdn_n (pwrdn_n),
        .d_in    (xtal_ready),
        .q_out   (xtal_s)
    );

    refclk_sync #(.STAGES(SYNC_STAGES)) u_sync_en (
        .ref_clk (ref_clk),
        .pwrdn_n (pwrdn_n),
        .d_in    (clk_en),
        .q_out   (en_s)
    );

    assign gate_on = xtal_s & en_s;

    refclk_phase_cnt #(.CNT_W(CNT_W)) u_cnt (
        .ref_clk    (ref_clk),
        .pwrdn_n    (pwrdn_n),
        .clr        (cnt_clr),
        .limit      (half_limit),
        .phase_last (phase_last)
    );

    refclk_div_fsm #(
        .HALF_FAST (HALF_FAST),
        .HALF_SLOW (HALF_SLOW),
        .CNT_W     (CNT_W)
    ) u_fsm (
        .ref_clk    (ref_clk),
        .pwrdn_n    (pwrdn_n),
        .gate_on    (gate_on),
        .div_fast   (div_fast),
        .phase_last (phase_last),
        .cnt_clr    (cnt_clr),
        .half_limit (half_limit),
        .clk_out    (clk_out)
    );
endmodule

// File: rtl/refclk_divider_chk.sv
module refclk_divider_chk #(
    parameter int unsigned HALF_FAST = 2,
    parameter int unsigned HALF_SLOW = 4
) (
    input logic ref_clk,
    input logic pwrdn_n,
    input logic gate_on,
    input logic clk_out
);
    logic [3:0] hi_cnt;
    logic [3:0] lo_cnt;

    // Run-length counters of the output level, saturating.
    always_ff @(posedge ref_clk or negedge pwrdn_n) begin
        if (!pwrdn_n) begin
            hi_cnt <= '0;
            lo_cnt <= '0;
        end else if (clk_out) begin
            lo_cnt <= '0;
            if (hi_cnt != 4'hF) hi_cnt <= hi_cnt + 1'b1;
        end else begin
            hi_cnt <= '0;
            if (lo_cnt != 4'hF) lo_cnt <= lo_cnt + 1'b1;
        end
    end

    assert_high_width_R6: assert property (@(posedge ref_clk) disable iff (!pwrdn_n)
        $fell(clk_out) |-> (hi_cnt == 4'(HALF_FAST) || hi_cnt == 4'(HALF_SLOW)));

    assert_low_width_R7: assert property (@(posedge ref_clk) disable iff (!pwrdn_n)
        $rose(clk_out) |-> (lo_cnt >= 4'(HALF_FAST)));

    assert_gated_quiet_R3: assert property (@(posedge ref_clk) disable iff (!pwrdn_n)
        (!gate_on && !clk_out) |=> !clk_out);

    assert_start_gated_R5: assert property (@(posedge ref_clk) disable iff (!pwrdn_n)
        $rose(clk_out) |-> $past(gate_on));
endmodule

bind refclk_divider refclk_divider_chk #(
    .HALF_FAST (HALF_FAST),
    .HALF_SLOW (HALF_SLOW)
) chk_i (
    .ref_clk (ref_clk),
    .pwrdn_n (pwrdn_n),
    .gate_on (gate_on),
    .clk_out (clk_out)
);

// File: tb/refclk_divider_tb_top.sv
module refclk_divider_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 4;
    // Each entry: {div_fast, expected half length}
    localparam logic [3:0] VEC [NVEC] = '{
        {1'b1, 3'd2}, {1'b0, 3'd4}, {1'b1, 3'd2}, {1'b0, 3'd4}
    };

    logic ref_clk = 1'b0;
    logic pwrdn_n = 1'b0;
    logic xtal_ready = 1'b0;
    logic clk_en = 1'b0;
    logic div_fast = 1'b0;
    logic clk_out;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) ref_clk = ~ref_clk;

    refclk_divider dut_i (
        .ref_clk    (ref_clk),
        .pwrdn_n    (pwrdn_n),
        .xtal_ready (xtal_ready),
        .clk_en     (clk_en),
        .div_fast   (div_fast),
        .clk_out    (clk_out)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Count falling-edge samples of one level, stopping at cap.
    task automatic run_len(input logic lvl, input int cap, output int n);
        n = 0;
        while (clk_out === lvl && n < cap) begin
            n++;
            @(negedge ref_clk);
        end
    endtask

    // Count falling-edge samples until the output is seen high.
    task automatic wait_rise(output int k);
        k = 0;
        do begin
            @(negedge ref_clk);
            k++;
        end while (!clk_out && k < 50);
    endtask

    task automatic do_reset();
        @(negedge ref_clk);
        pwrdn_n = 1'b0; xtal_ready = 1'b0; clk_en = 1'b0;
        repeat (3) @(negedge ref_clk);
        pwrdn_n = 1'b1;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int n;
        int k;
        // R4: output low while powered down
        repeat (2) @(negedge ref_clk);
        check("R4 reset low", int'(clk_out), 0);

        // Table walk: R1/R2/R5/R6 across ratios
        for (int v = 0; v < NVEC; v++) begin
            do_reset();
            div_fast = VEC[v][3];
            xtal_ready = 1'b1; clk_en = 1'b1;
            wait_rise(k);
            check("R5 start latency", k, 3);
            for (int p = 0; p < 2; p++) begin
                run_len(1'b1, 20, n);
                check(VEC[v][3] ? "R1 high width" : "R2 high width", n, int'(VEC[v][2:0]));
                run_len(1'b0, 20, n);
                check(VEC[v][3] ? "R1 low width" : "R2 low width", n, int'(VEC[v][2:0]));
            end
        end

        // R8: ratio change mid-high takes effect at falling edge
        do_reset();
        div_fast = 1'b0; xtal_ready = 1'b1; clk_en = 1'b1;
        wait_rise(k);
        div_fast = 1'b1;
        run_len(1'b1, 20, n);
        check("R8 old high kept", n, 4);
        run_len(1'b0, 20, n);
        check("R8 new low", n, 2);
        run_len(1'b1, 20, n);
        check("R8 new high", n, 2);

        // R9/R3: enable drop during high
        do_reset();
        div_fast = 1'b0; xtal_ready = 1'b1; clk_en = 1'b1;
        wait_rise(k);
        clk_en = 1'b0;
        run_len(1'b1, 20, n);
        check("R9 high completes", n, 4);
        run_len(1'b0, 20, n);
        check("R3 stays low", n, 20);

        // R7: re-enable restarts with full period
        clk_en = 1'b1;
        wait_rise(k);
        check("R7 restart latency", k, 3);
        run_len(1'b1, 20, n);
        check("R7 first high full", n, 4);
        run_len(1'b0, 20, n);
        check("R7 first low full", n, 4);

        // R10: crystal not ready gates output
        do_reset();
        div_fast = 1'b1; clk_en = 1'b1; xtal_ready = 1'b0;
        @(negedge ref_clk);
        run_len(1'b0, 20, n);
        check("R10 low without xtal", n, 20);
        xtal_ready = 1'b1;
        wait_rise(k);
        check("R10 start latency", k, 3);
        run_len(1'b1, 20, n);
        check("R10 first high full", n, 2);

        // R4: asynchronous power-down during high
        do_reset();
        div_fast = 1'b0; xtal_ready = 1'b1; clk_en = 1'b1;
        wait_rise(k);
        #1 pwrdn_n = 1'b0;
        #1 check("R4 async low", int'(clk_out), 0);
        repeat (5) @(negedge ref_clk);
        check("R4 held low", int'(clk_out), 0);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule